// File: doc/BRIEF.md
# Nibble-Addressed Command Register File

This block sits behind a byte-oriented serial receiver and turns each received command byte into a register update. The low nibble of the byte picks one of sixteen interface slots. The high nibble is the value written into that slot. Most slots only stage operands for later commands: four nibbles of a 16-bit data-hold word, a calibration/EEPROM address, a readback pointer, and analog select and timeout codes.

Two slots act at once. A write to the command slot stores an opcode and sends a one-cycle execute strobe, with that opcode, to the downstream engines:
- calibration load or read
- EEPROM write, read, full erase or page erase
- register readback
- analog output

A write to the re-initialize slot pulses a reset request back to the serial receiver.

Downstream engines return data through two load ports. A word response fills the whole data-hold register. A byte response fills its low byte. A combinational readback multiplexer presents one byte chosen by the readback pointer: packed pairs of staged fields, live status bytes, or a fixed check pattern. A serial transmitter can send this byte when a readback command runs. While the downstream logic reports busy, for example during an erase, a command is held pending and its strobe goes out only when busy drops.

Top module: `nibcmd_regfile`

## Requirements
- R1: After reset, every staged field and `hold_q` read zero, and `exec_valid` and `rx_reinit` are low.
- R2: A byte whose address nibble (bits 3:0) is 0, 1, 2 or 3 writes its data nibble (bits 7:4) into `hold_q` bits 3:0, 7:4, 11:8 or 15:12 respectively. The other bits of `hold_q` do not change.
- R3: Address 6 writes `cal_addr`. Address 7 writes EEPROM address bits 7:4. Address 8 writes `rb_ptr`. `ee_addr` is always {`rb_ptr`[1:0], address-7 nibble, address-6 nibble}.
- R4: Address 10 writes `atim` and address 11 writes `asel`. Addresses 4, 5, 12, 13 and 14 change no output and raise no pulse.
- R5: Address 9 stores the data nibble as the opcode, which is visible on `exec_op`. For opcodes 0 to 7, with busy low, `exec_valid` is high for exactly the one cycle after the byte is accepted. Opcodes 8 to 15 are stored but raise no strobe.
- R6: A byte may be accepted on every clock. Command bytes on consecutive cycles give strobes on consecutive cycles, each with its own opcode.
- R7: Address 15, with any data, raises `rx_reinit` for exactly the cycle after the byte and changes no staged field.
- R8: `rb_byte` is chosen by `rb_ptr`:
  - 0: `hold_q`[7:0]
  - 1: `hold_q`[15:8]
  - 2: {`cal_addr`, `cal_addr`}
  - 3: {opcode, `rb_ptr`}
  - 4: {`asel`, `atim`}
  - 5: `ee_addr`[7:0]
  - 6: `ee_rdata`
  - 7: `temp_index`
  - 8: `bit_clk`
  - 9: 0x00
  - 10 to 15: 0xCA
- R9: While `busy` is high, no strobe is raised. A valid command written during busy stays pending. Its strobe comes in the cycle after the first clock at which busy is low. A later command byte replaces the pending one, and an opcode of 8 to 15 cancels it.
- R10: `cal_rsp_vld` loads `cal_rdata` into all of `hold_q`. `ee_rsp_vld` loads `ee_rdata` into `hold_q`[7:0]. A serial data-hold write in the same cycle takes precedence for its own nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | A received command byte is present |
| byte_data | input | 8 | Command byte: data nibble [7:4], address nibble [3:0] |
| busy | input | 1 | Downstream engine busy; holds strobes off |
| cal_rsp_vld | input | 1 | Calibration read word is valid |
| cal_rdata | input | 16 | Calibration read word |
| ee_rsp_vld | input | 1 | EEPROM read byte is valid |
| ee_rdata | input | 8 | EEPROM data byte |
| temp_index | input | 8 | Current temperature index |
| bit_clk | input | 8 | Learned bit-time count |
| exec_valid | output | 1 | One-cycle execute strobe |
| exec_op | output | 4 | Opcode of the stored command |
| rx_reinit | output | 1 | One-cycle receiver re-initialize request |
| hold_q | output | 16 | Data-hold register |
| cal_addr | output | 4 | Calibration register address / EEPROM address nibble 0 |
| ee_addr | output | 10 | EEPROM byte address |
| rb_ptr | output | 4 | Readback pointer |
| atim | output | 4 | Analog timeout code |
| asel | output | 4 | Analog select code |
| rb_byte | output | 8 | Readback byte |

## Verification
The hardest case is a command that arrives during busy and is then overtaken. The bench reaches it by raising busy and sending two command bytes, and checks that only the second is issued, once, when busy falls. A second run sends a valid command followed by an opcode of 8 or above, and checks that no strobe appears after busy clears. Same-cycle collisions between a response load and a serial nibble write are forced by driving both in one cycle. All 256 byte values are swept against an arithmetic model of the slot map.

// File: rtl/nibcmd_pkg.sv
package nibcmd_pkg;
  localparam int SLOT_BITS = 4;

  localparam logic [SLOT_BITS-1:0] SLOT_HOLD0  = 4'd0;
  localparam logic [SLOT_BITS-1:0] SLOT_HOLD1  = 4'd1;
  localparam logic [SLOT_BITS-1:0] SLOT_HOLD2  = 4'd2;
  localparam logic [SLOT_BITS-1:0] SLOT_HOLD3  = 4'd3;
  localparam logic [SLOT_BITS-1:0] SLOT_EA0    = 4'd6;
  localparam logic [SLOT_BITS-1:0] SLOT_EA1    = 4'd7;
  localparam logic [SLOT_BITS-1:0] SLOT_PTR    = 4'd8;
  localparam logic [SLOT_BITS-1:0] SLOT_CMD    = 4'd9;
  localparam logic [SLOT_BITS-1:0] SLOT_ATIM   = 4'd10;
  localparam logic [SLOT_BITS-1:0] SLOT_ASEL   = 4'd11;
  localparam logic [SLOT_BITS-1:0] SLOT_REINIT = 4'd15;

  typedef enum logic [SLOT_BITS-1:0] {
    RB_HOLD_LO  = 4'd0,
    RB_HOLD_HI  = 4'd1,
    RB_CAL_PAIR = 4'd2,
    RB_CMD_PTR  = 4'd3,
    RB_ANALOG   = 4'd4,
    RB_EE_LO    = 4'd5,
    RB_EE_DATA  = 4'd6,
    RB_TEMP     = 4'd7,
    RB_BITCLK   = 4'd8,
    RB_ZERO     = 4'd9
  } rb_sel_e;

  localparam int NUM_OPS = 8;
endpackage

// File: rtl/nibcmd_decode.sv
module nibcmd_decode #(
  parameter int NIB_W = 4
) (
  input  logic               byte_valid,
  input  logic [2*NIB_W-1:0] byte_data,
  output logic [(1<<NIB_W)-1:0] wr_en,
  output logic [NIB_W-1:0]   wr_nib
);
  localparam int SLOTS = 1 << NIB_W;

  logic [NIB_W-1:0] addr_nib;

  assign addr_nib = byte_data[NIB_W-1:0];
  assign wr_nib   = byte_data[2*NIB_W-1:NIB_W];

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    assign wr_en[k] = byte_valid && (addr_nib == NIB_W'(k));
  end
endmodule

// File: rtl/nibcmd_regs.sv
module nibcmd_regs #(
  parameter int NIB_W     = 4,
  parameter int HOLD_NIBS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [(1<<NIB_W)-1:0]       wr_en,
  input  logic [NIB_W-1:0]            wr_nib,
  input  logic                        word_ld,
  input  logic [NIB_W*HOLD_NIBS-1:0]  word_in,
  input  logic                        low_ld,
  input  logic [2*NIB_W-1:0]          low_in,
  output logic [NIB_W*HOLD_NIBS-1:0]  hold_q,
  output logic [NIB_W-1:0]            ea0_q,
  output logic [NIB_W-1:0]            ea1_q,
  output logic [NIB_W-1:0]            ptr_q,
  output logic [NIB_W-1:0]            cmd_q,
  output logic [NIB_W-1:0]            atim_q,
  output logic [NIB_W-1:0]            asel_q
);
  import nibcmd_pkg::*;

  localparam int LOW_NIBS = 2;

  logic [NIB_W-1:0] hold_r [HOLD_NIBS];
  logic [NIB_W-1:0] hold_d [HOLD_NIBS];

  for (genvar i = 0; i < HOLD_NIBS; i++) begin : g_hold
    always_comb begin
      hold_d[i] = hold_r[i];
      if (word_ld) begin
        hold_d[i] = word_in[i*NIB_W +: NIB_W];
      end
      if (low_ld && (i < LOW_NIBS)) begin
        hold_d[i] = low_in[(i%LOW_NIBS)*NIB_W +: NIB_W];
      end
      if (wr_en[i]) begin
        hold_d[i] = wr_nib;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_r[i] <= '0;
      end else begin
        hold_r[i] <= hold_d[i];
      end
    end

    assign hold_q[i*NIB_W +: NIB_W] = hold_r[i];
  end

  logic [NIB_W-1:0] ea0_d, ea1_d, ptr_d, cmd_d, atim_d, asel_d;

  always_comb begin
    ea0_d  = ea0_q;
    ea1_d  = ea1_q;
    ptr_d  = ptr_q;
    cmd_d  = cmd_q;
    atim_d = atim_q;
    asel_d = asel_q;
    if (wr_en[SLOT_EA0])  ea0_d  = wr_nib;
    if (wr_en[SLOT_EA1])  ea1_d  = wr_nib;
    if (wr_en[SLOT_PTR])  ptr_d  = wr_nib;
    if (wr_en[SLOT_CMD])  cmd_d  = wr_nib;
    if (wr_en[SLOT_ATIM]) atim_d = wr_nib;
    if (wr_en[SLOT_ASEL]) asel_d = wr_nib;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea0_q  <= '0;
      ea1_q  <= '0;
      ptr_q  <= '0;
      cmd_q  <= '0;
      atim_q <= '0;
      asel_q <= '0;
    end else begin
      ea0_q  <= ea0_d;
      ea1_q  <= ea1_d;
      ptr_q  <= ptr_d;
      cmd_q  <= cmd_d;
      atim_q <= atim_d;
      asel_q <= asel_d;
    end
  end
endmodule

// File: rtl/nibcmd_issue.sv
module nibcmd_issue #(
  parameter int NIB_W   = 4,
  parameter int NUM_OPS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [NIB_W-1:0] cmd_code,
  input  logic             busy,
  output logic             strobe
);
  logic code_ok;
  logic pend_q, pend_d;
  logic stb_d;

  assign code_ok = (int'(cmd_code) < NUM_OPS);

  always_comb begin
    pend_d = pend_q && busy;
    stb_d  = pend_q && !busy;
    if (cmd_wr) begin
      pend_d = code_ok && busy;
      stb_d  = code_ok && !busy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      strobe <= 1'b0;
    end else begin
      pend_q <= pend_d;
      strobe <= stb_d;
    end
  end
endmodule

// File: rtl/nibcmd_rbmux.sv
module nibcmd_rbmux #(
  parameter int           NIB_W     = 4,
  parameter int           HOLD_NIBS = 4,
  parameter logic [7:0]   CHECK_PAT = 8'hCA
) (
  input  logic [NIB_W-1:0]           sel,
  input  logic [NIB_W*HOLD_NIBS-1:0] hold,
  input  logic [NIB_W-1:0]           ea0,
  input  logic [NIB_W-1:0]           ea1,
  input  logic [NIB_W-1:0]           cmd,
  input  logic [NIB_W-1:0]           atim,
  input  logic [NIB_W-1:0]           asel,
  input  logic [2*NIB_W-1:0]         ee_rdata,
  input  logic [2*NIB_W-1:0]         temp_index,
  input  logic [2*NIB_W-1:0]         bit_clk,
  output logic [2*NIB_W-1:0]         rb_byte
);
  import nibcmd_pkg::*;

  localparam int BYTE_W = 2 * NIB_W;

  always_comb begin
    unique case (sel)
      RB_HOLD_LO:  rb_byte = hold[BYTE_W-1:0];
      RB_HOLD_HI:  rb_byte = hold[2*BYTE_W-1:BYTE_W];
      RB_CAL_PAIR: rb_byte = {ea0, ea0};
      RB_CMD_PTR:  rb_byte = {cmd, sel};
      RB_ANALOG:   rb_byte = {asel, atim};
      RB_EE_LO:    rb_byte = {ea1, ea0};
      RB_EE_DATA:  rb_byte = ee_rdata;
      RB_TEMP:     rb_byte = temp_index;
      RB_BITCLK:   rb_byte = bit_clk;
      RB_ZERO:     rb_byte = '0;
      default:     rb_byte = BYTE_W'(CHECK_PAT);
    endcase
  end
endmodule

// File: rtl/nibcmd_regfile.sv
module nibcmd_regfile #(
  parameter int NIB_W     = 4,
  parameter int HOLD_NIBS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        byte_valid,
  input  logic [2*NIB_W-1:0]          byte_data,
  input  logic                        busy,
  input  logic                        cal_rsp_vld,
  input  logic [NIB_W*HOLD_NIBS-1:0]  cal_rdata,
  input  logic                        ee_rsp_vld,
  input  logic [2*NIB_W-1:0]          ee_rdata,
  input  logic [2*NIB_W-1:0]          temp_index,
  input  logic [2*NIB_W-1:0]          bit_clk,
  output logic                        exec_valid,
  output logic [NIB_W-1:0]            exec_op,
  output logic                        rx_reinit,
  output logic [NIB_W*HOLD_NIBS-1:0]  hold_q,
  output logic [NIB_W-1:0]            cal_addr,
  output logic [2*NIB_W+1:0]          ee_addr,
  output logic [NIB_W-1:0]            rb_ptr,
  output logic [NIB_W-1:0]            atim,
  output logic [NIB_W-1:0]            asel,
  output logic [2*NIB_W-1:0]          rb_byte
);
  import nibcmd_pkg::*;

  localparam int SLOTS = 1 << NIB_W;

  logic [SLOTS-1:0] wr_en;
  logic [NIB_W-1:0] wr_nib;
  logic [NIB_W-1:0] ea0_q, ea1_q, cmd_q;
  logic             reinit_d, reinit_q;

  nibcmd_decode #(.NIB_W(NIB_W)) u_dec (
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .wr_en      (wr_en),
    .wr_nib     (wr_nib)
  );

  nibcmd_regs #(.NIB_W(NIB_W), .HOLD_NIBS(HOLD_NIBS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_nib  (wr_nib),
    .word_ld (cal_rsp_vld),
    .word_in (cal_rdata),
    .low_ld  (ee_rsp_vld),
    .low_in  (ee_rdata),
    .hold_q  (hold_q),
    .ea0_q   (ea0_q),
    .ea1_q   (ea1_q),
    .ptr_q   (rb_ptr),
    .cmd_q   (cmd_q),
    .atim_q  (atim),
    .asel_q  (asel)
  );

  nibcmd_issue #(.NIB_W(NIB_W), .NUM_OPS(NUM_OPS)) u_issue (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (wr_en[SLOT_CMD]),
    .cmd_code (wr_nib),
    .busy     (busy),
    .strobe   (exec_valid)
  );

  nibcmd_rbmux #(.NIB_W(NIB_W), .HOLD_NIBS(HOLD_NIBS)) u_rb (
    .sel        (rb_ptr),
    .hold       (hold_q),
    .ea0        (ea0_q),
    .ea1        (ea1_q),
    .cmd        (cmd_q),
    .atim       (atim),
    .asel       (asel),
    .ee_rdata   (ee_rdata),
    .temp_index (temp_index),
    .bit_clk    (bit_clk),
    .rb_byte    (rb_byte)
  );

  assign reinit_d = wr_en[SLOT_REINIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reinit_q <= 1'b0;
    end else begin
      reinit_q <= reinit_d;
    end
  end

  assign rx_reinit = reinit_q;
  assign exec_op   = cmd_q;
  assign cal_addr  = ea0_q;
  assign ee_addr   = {rb_ptr[1:0], ea1_q, ea0_q};
endmodule

// File: rtl/nibcmd_regfile_chk.sv
module nibcmd_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        byte_valid,
  input logic [7:0]  byte_data,
  input logic        busy,
  input logic        cal_rsp_vld,
  input logic        ee_rsp_vld,
  input logic        exec_valid,
  input logic [3:0]  exec_op,
  input logic        rx_reinit,
  input logic [15:0] hold_q,
  input logic [9:0]  ee_addr,
  input logic [3:0]  rb_ptr,
  input logic [7:0]  rb_byte
);
  logic rsvd_addr;
  assign rsvd_addr = (byte_data[3:0] == 4'd4) || (byte_data[3:0] == 4'd5) ||
                     (byte_data[3:0] == 4'd12) || (byte_data[3:0] == 4'd13) ||
                     (byte_data[3:0] == 4'd14);

  assert_strobe_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |-> !$past(busy));

  assert_strobe_op_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |-> (exec_op[3] == 1'b0));

  assert_reinit_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reinit |-> $past(byte_valid && (byte_data[3:0] == 4'hF)));

  assert_hold_nib0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && (byte_data[3:0] == 4'd0)) |=> (hold_q[3:0] == $past(byte_data[7:4])));

  assert_check_pattern_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_ptr >= 4'd10) |-> (rb_byte == 8'hCA));

  assert_reserved_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && rsvd_addr && !cal_rsp_vld && !ee_rsp_vld) |=>
      ($stable(hold_q) && $stable(ee_addr) && $stable(rb_ptr) && !rx_reinit));
endmodule

bind nibcmd_regfile nibcmd_regfile_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .byte_valid  (byte_valid),
  .byte_data   (byte_data),
  .busy        (busy),
  .cal_rsp_vld (cal_rsp_vld),
  .ee_rsp_vld  (ee_rsp_vld),
  .exec_valid  (exec_valid),
  .exec_op     (exec_op),
  .rx_reinit   (rx_reinit),
  .hold_q      (hold_q),
  .ee_addr     (ee_addr),
  .rb_ptr      (rb_ptr),
  .rb_byte     (rb_byte)
);

// File: tb/nibcmd_regfile_bench.sv
module nibcmd_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_valid, busy, cal_rsp_vld, ee_rsp_vld;
  logic [7:0]  byte_data, ee_rdata, temp_index, bit_clk;
  logic [15:0] cal_rdata;
  logic        exec_valid, rx_reinit;
  logic [3:0]  exec_op, cal_addr, rb_ptr, atim, asel;
  logic [9:0]  ee_addr;
  logic [15:0] hold_q;
  logic [7:0]  rb_byte;

  int n_chk  = 0;
  int n_fail = 0;

  logic [15:0] m_hold;
  logic [3:0]  m_ea0, m_ea1, m_ptr, m_cmd, m_atim, m_asel;

  always #5 clk = ~clk;

  nibcmd_regfile u_nibcmd_regfile (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .busy(busy), .cal_rsp_vld(cal_rsp_vld), .cal_rdata(cal_rdata),
    .ee_rsp_vld(ee_rsp_vld), .ee_rdata(ee_rdata), .temp_index(temp_index),
    .bit_clk(bit_clk), .exec_valid(exec_valid), .exec_op(exec_op),
    .rx_reinit(rx_reinit), .hold_q(hold_q), .cal_addr(cal_addr),
    .ee_addr(ee_addr), .rb_ptr(rb_ptr), .atim(atim), .asel(asel),
    .rb_byte(rb_byte)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_apply(input logic [7:0] b);
    logic [3:0] a, d;
    a = b[3:0];
    d = b[7:4];
    case (a)
      4'd0: m_hold[3:0]   = d;
      4'd1: m_hold[7:4]   = d;
      4'd2: m_hold[11:8]  = d;
      4'd3: m_hold[15:12] = d;
      4'd6: m_ea0  = d;
      4'd7: m_ea1  = d;
      4'd8: m_ptr  = d;
      4'd9: m_cmd  = d;
      4'd10: m_atim = d;
      4'd11: m_asel = d;
      default: ;
    endcase
  endtask

  function automatic logic [7:0] rb_model();
    case (m_ptr)
      4'd0: return m_hold[7:0];
      4'd1: return m_hold[15:8];
      4'd2: return {m_ea0, m_ea0};
      4'd3: return {m_cmd, m_ptr};
      4'd4: return {m_asel, m_atim};
      4'd5: return {m_ea1, m_ea0};
      4'd6: return ee_rdata;
      4'd7: return temp_index;
      4'd8: return bit_clk;
      4'd9: return 8'h00;
      default: return 8'hCA;
    endcase
  endfunction

  task automatic check_fields();
    chk("R2 hold_q", 32'(hold_q), 32'(m_hold));
    chk("R3 cal_addr", 32'(cal_addr), 32'(m_ea0));
    chk("R3 ee_addr", 32'(ee_addr), 32'({m_ptr[1:0], m_ea1, m_ea0}));
    chk("R3 rb_ptr", 32'(rb_ptr), 32'(m_ptr));
    chk("R4 atim", 32'(atim), 32'(m_atim));
    chk("R4 asel", 32'(asel), 32'(m_asel));
    chk("R5 exec_op", 32'(exec_op), 32'(m_cmd));
  endtask

  // Drive a byte for one cycle; returns at the negedge after capture.
  task automatic send(input logic [7:0] b);
    byte_valid = 1'b1;
    byte_data  = b;
    model_apply(b);
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; byte_valid = 1'b0; byte_data = '0; busy = 1'b0;
    cal_rsp_vld = 1'b0; cal_rdata = '0; ee_rsp_vld = 1'b0;
    ee_rdata = 8'h93; temp_index = 8'h6A; bit_clk = 8'h41;
    m_hold = '0; m_ea0 = '0; m_ea1 = '0; m_ptr = '0; m_cmd = '0; m_atim = '0; m_asel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_fields();
    chk("R1 exec_valid", 32'(exec_valid), 0);
    chk("R1 rx_reinit", 32'(rx_reinit), 0);
    chk("R1 rb_byte", 32'(rb_byte), 0);

    // Sweep of all 256 bytes: R2 R3 R4 R5 R7
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = 8'(v);
      send(b);
      check_fields();
      chk("R5 strobe", 32'(exec_valid), 32'((b[3:0] == 4'd9) && (b[7:4] < 4'd8)));
      chk("R7 reinit", 32'(rx_reinit), 32'(b[3:0] == 4'hF));
      chk("R8 rb_byte", 32'(rb_byte), 32'(rb_model()));
      @(negedge clk);
      chk("R5 strobe one cycle", 32'(exec_valid), 0);
      chk("R7 reinit one cycle", 32'(rx_reinit), 0);
    end

    // R8 readback sweep over all pointers
    send(8'h50); send(8'hA1); send(8'h72); send(8'h33);
    send(8'hD6); send(8'h47); send(8'h9A); send(8'h2B); send(8'hC9);
    for (int p = 0; p < 16; p++) begin
      send({4'(p), 4'd8});
      chk("R8 rb_byte sweep", 32'(rb_byte), 32'(rb_model()));
      chk("R3 ee_addr ptr bits", 32'(ee_addr), 32'({m_ptr[1:0], m_ea1, m_ea0}));
    end

    // R6 back-to-back commands
    byte_valid = 1'b1; byte_data = 8'h19; model_apply(8'h19);
    @(negedge clk);
    chk("R6 first strobe", 32'(exec_valid), 1);
    chk("R6 first op", 32'(exec_op), 1);
    byte_data = 8'h29; model_apply(8'h29);
    @(negedge clk);
    byte_valid = 1'b0;
    chk("R6 second strobe", 32'(exec_valid), 1);
    chk("R6 second op", 32'(exec_op), 2);
    @(negedge clk);
    chk("R6 strobe ends", 32'(exec_valid), 0);

    // R9 busy hold-off, later command replaces pending
    busy = 1'b1;
    send(8'h19);
    chk("R9 no strobe while busy", 32'(exec_valid), 0);
    send(8'h49);
    repeat (3) begin
      @(negedge clk);
      chk("R9 still held", 32'(exec_valid), 0);
    end
    busy = 1'b0;
    @(negedge clk);
    chk("R9 deferred strobe", 32'(exec_valid), 1);
    chk("R9 deferred op", 32'(exec_op), 4);
    @(negedge clk);
    chk("R9 single deferred strobe", 32'(exec_valid), 0);

    // R9 reserved opcode cancels pending
    busy = 1'b1;
    send(8'h29);
    send(8'h89);
    busy = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R9 cancelled", 32'(exec_valid), 0);
    end

    // R10 response loads
    cal_rsp_vld = 1'b1; cal_rdata = 16'hBEEF;
    @(negedge clk);
    cal_rsp_vld = 1'b0; m_hold = 16'hBEEF;
    chk("R10 word load", 32'(hold_q), 32'h0000BEEF);
    ee_rsp_vld = 1'b1; ee_rdata = 8'h5A;
    @(negedge clk);
    ee_rsp_vld = 1'b0; m_hold[7:0] = 8'h5A;
    chk("R10 byte load", 32'(hold_q), 32'h0000BE5A);
    ee_rsp_vld = 1'b1; ee_rdata = 8'h3C;
    byte_valid = 1'b1; byte_data = 8'h70;
    @(negedge clk);
    ee_rsp_vld = 1'b0; byte_valid = 1'b0;
    chk("R10 nibble write wins", 32'(hold_q), 32'h0000BE37);
    cal_rsp_vld = 1'b1; cal_rdata = 16'h1234;
    byte_valid = 1'b1; byte_data = 8'hF3;
    @(negedge clk);
    cal_rsp_vld = 1'b0; byte_valid = 1'b0;
    chk("R10 word load with top nibble write", 32'(hold_q), 32'h0000F234);

    // R1 reset clears again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 hold after reset", 32'(hold_q), 0);
    chk("R1 ee_addr after reset", 32'(ee_addr), 0);
    chk("R1 asel after reset", 32'(asel), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule